// File: doc/BRIEF.md
# Mode-Checked GPIO Port Access Engine

This engine serves single-pin requests aimed at a 20-pin mixed-signal peripheral. Each pin has a 16-bit setup word. The engine holds these words on a static input and uses the top four bits of each as that pin's operating mode. A requester hands over a pin index together with a command. The command either drives the pin to a level or samples its current state. The engine answers with a one-cycle status pulse that says whether the access was carried out.

Pin levels are packed into 16-bit registers that sit on a simple request/acknowledge register bus. Pins 0 to 15 live in a low word and pins 16 to 19 live in a separate high word. Output levels and input samples use different addresses. A drive command fetches the whole output word, changes one bit and stores the word back. A sample command fetches the input word and returns it shifted down so the pin's bit lands at bit 0. A request whose pin index or mode does not permit the access is refused, and in that case the bus is not touched at all. Only one request is handled at a time. A busy flag keeps further requests out until the status has been given.

Top module: `gpio_port_engine`

## Requirements
- R1: The mode of pin p is bits 15:12 of that pin's setup word (bits p*16+15 down to p*16+12 of `cfgWords`). No other bit of the word affects the decision.
- R2: A drive command succeeds only when the pin's mode equals 3 (`WRITE_MODE`). For any other mode the engine answers with `rspOk`=0 and issues no bus transfer.
- R3: A sample command succeeds only when the pin's mode equals 1 (`READ_MODE`). For any other mode the engine answers with `rspOk`=0 and issues no bus transfer.
- R4: A pin index of 20 or more is refused with `rspOk`=0 and no bus transfer.
- R5: Pins 0–15 use bit p of the low word, and pins 16–19 use bit p−16 of the high word. Output words sit at `OUT_LO_ADDR`/`OUT_HI_ADDR` (defaults 0x0D/0x0E) and input words at `IN_LO_ADDR`/`IN_HI_ADDR` (defaults 0x0B/0x0C).
- R6: An accepted drive command makes exactly two transfers to the same output address. The first is a read (`busWe`=0). The second is a write (`busWe`=1) of the fetched word with only the pin's bit changed: it is set when `reqLevel`=1 and cleared when `reqLevel`=0.
- R7: An accepted sample command makes exactly one read of the input word. It answers with `rspOk`=1 and `rspData` equal to that word shifted right by the pin's bit position.
- R8: `busy` is 1 from the cycle after a request is taken until the cycle after `rspValid`. A `reqValid` seen while `busy` is 1 is ignored: it produces no transfer and no response.
- R9: Every taken request produces exactly one single-cycle `rspValid`. `rspData` is 0 for drive commands and for refusals.
- R10: While `busReq` is 1 and `busAck` is 0, `busReq`, `busAddr`, `busWe` and `busWdata` hold their values into the next cycle.
- R11: After reset, `busy`, `busReq` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWords | input | NUM_PORTS*CFG_W | Setup word of each pin; pin p occupies bits p*16+15:p*16 |
| reqValid | input | 1 | Request strobe, taken when `busy` is 0 |
| reqWrite | input | 1 | 1 = drive command, 0 = sample command |
| reqPort | input | PORT_W (5) | Pin index |
| reqLevel | input | 1 | Level to drive on a drive command |
| busy | output | 1 | A request is in progress |
| rspValid | output | 1 | One-cycle status pulse |
| rspOk | output | 1 | Status: 1 = carried out, 0 = refused |
| rspData | output | DATA_W | Shifted input word on a successful sample, otherwise 0 |
| busReq | output | 1 | Register bus transfer request |
| busWe | output | 1 | Transfer direction: 1 = write |
| busAddr | output | ADDR_W | Register address |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Transfer completes in this cycle |
| busRdata | input | DATA_W | Read data, valid with `busAck` |

## Verification
Some properties are checked by assertions on every cycle. The bus request must hold steady until it is acknowledged. Every request must use one of the four word addresses, and writes must go only to output words. A refused request must go straight to its status without raising the bus request. A taken request must raise `busy`, and the status must be a lone pulse. Other behaviour is shown only by the bench's scenarios. These cover the mode-field slice, where decoy modes match the allowed values in their low bits or a 3 sits in bits 11:8. They also cover bit routing across the low and high words, the exact read-modify-write value, the shifted sample data, and the dropping of requests raised while busy. The bench runs these scenarios at several bus latencies against its own register model.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_BUSRD,
    ST_BUSWR,
    ST_DONE
  } engState_t;

  typedef struct packed {
    logic latchReq;     // take the request into the datapath
    logic captureWord;  // store the word returned by the bus
    logic markOk;       // the access has completed successfully
  } engStrobe_t;

endpackage

// File: rtl/gpe_ctrl.sv
module gpe_ctrl
  import gpe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isWrite,
  input  logic       accessOk,
  input  logic       busAck,
  output engStrobe_t strobes,
  output logic       busReq,
  output logic       busWe,
  output logic       busy,
  output logic       rspValid
);

  engState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = ST_CHECK;
      ST_CHECK: stateD = accessOk ? ST_BUSRD : ST_DONE;
      ST_BUSRD: if (busAck) stateD = isWrite ? ST_BUSWR : ST_DONE;
      ST_BUSWR: if (busAck) stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes             = '0;
    strobes.latchReq    = (stateQ == ST_IDLE) && reqValid;
    strobes.captureWord = (stateQ == ST_BUSRD) && busAck;
    strobes.markOk      = ((stateQ == ST_BUSRD) && busAck && !isWrite) ||
                          ((stateQ == ST_BUSWR) && busAck);
  end

  assign busReq   = (stateQ == ST_BUSRD) || (stateQ == ST_BUSWR);
  assign busWe    = (stateQ == ST_BUSWR);
  assign busy     = (stateQ != ST_IDLE);
  assign rspValid = (stateQ == ST_DONE);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_refuse_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_CHECK) && !accessOk) |=> (rspValid && !busReq));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_no_bus_at_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busReq);

endmodule

// File: rtl/gpe_datapath.sv
module gpe_datapath
  import gpe_pkg::*;
#(
  parameter int NUM_PORTS = 20,
  parameter int CFG_W     = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 7,
  parameter int MODE_W    = 4,
  parameter logic [ADDR_W-1:0] OUT_LO_ADDR = 7'h0D,
  parameter logic [ADDR_W-1:0] OUT_HI_ADDR = 7'h0E,
  parameter logic [ADDR_W-1:0] IN_LO_ADDR  = 7'h0B,
  parameter logic [ADDR_W-1:0] IN_HI_ADDR  = 7'h0C,
  parameter logic [MODE_W-1:0] WRITE_MODE  = 4'd3,
  parameter logic [MODE_W-1:0] READ_MODE   = 4'd1,
  localparam int PORT_W = $clog2(NUM_PORTS + 1),
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  engStrobe_t                strobes,
  input  logic                      reqWrite,
  input  logic [PORT_W-1:0]         reqPort,
  input  logic                      reqLevel,
  input  logic [NUM_PORTS*CFG_W-1:0] cfgWords,
  input  logic [DATA_W-1:0]         busRdata,
  output logic                      isWrite,
  output logic                      accessOk,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busWdata,
  output logic                      rspOk,
  output logic [DATA_W-1:0]         rspData
);

  localparam int LOW_W = CFG_W - MODE_W;

  logic [PORT_W-1:0] portQ;
  logic              writeQ;
  logic              levelQ;
  logic              okQ;
  logic [DATA_W-1:0] wordQ;

  logic [MODE_W-1:0] modeArr [NUM_PORTS];
  logic [NUM_PORTS*LOW_W-1:0] unusedCfgLow;
  logic              unusedCfgParity;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cfgSplit
    assign modeArr[p] = cfgWords[p*CFG_W + CFG_W - 1 -: MODE_W];
    assign unusedCfgLow[p*LOW_W +: LOW_W] = cfgWords[p*CFG_W +: LOW_W];
  end
  assign unusedCfgParity = ^unusedCfgLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ  <= '0;
      writeQ <= 1'b0;
      levelQ <= 1'b0;
      okQ    <= 1'b0;
      wordQ  <= '0;
    end else begin
      if (strobes.latchReq) begin
        portQ  <= reqPort;
        writeQ <= reqWrite;
        levelQ <= reqLevel;
        okQ    <= 1'b0;
      end
      if (strobes.captureWord) wordQ <= busRdata;
      if (strobes.markOk)      okQ   <= 1'b1;
    end
  end

  logic [MODE_W-1:0] modeSel;
  always_comb begin
    modeSel = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (portQ == PORT_W'(i)) modeSel = modeArr[i];
    end
  end

  logic              inRange;
  logic              isHigh;
  logic [PORT_W-1:0] relPort;
  logic [BIT_W-1:0]  bitPos;
  logic [DATA_W-1:0] bitMask;

  assign inRange  = portQ < PORT_W'(NUM_PORTS);
  assign isHigh   = portQ >= PORT_W'(DATA_W);
  assign relPort  = isHigh ? (portQ - PORT_W'(DATA_W)) : portQ;
  assign bitPos   = relPort[BIT_W-1:0];
  assign bitMask  = DATA_W'(1) << bitPos;

  assign isWrite  = writeQ;
  assign accessOk = inRange && (writeQ ? (modeSel == WRITE_MODE)
                                       : (modeSel == READ_MODE));

  always_comb begin
    if (writeQ) busAddr = isHigh ? OUT_HI_ADDR : OUT_LO_ADDR;
    else        busAddr = isHigh ? IN_HI_ADDR  : IN_LO_ADDR;
  end

  assign busWdata = levelQ ? (wordQ | bitMask) : (wordQ & ~bitMask);
  assign rspOk    = okQ;
  assign rspData  = (okQ && !writeQ) ? (wordQ >> bitPos) : '0;

  assert_refused_no_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!okQ || writeQ) |-> (rspData == '0));

endmodule

// File: rtl/gpio_port_engine.sv
module gpio_port_engine
  import gpe_pkg::*;
#(
  parameter int NUM_PORTS = 20,
  parameter int CFG_W     = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] OUT_LO_ADDR = 7'h0D,
  parameter logic [ADDR_W-1:0] OUT_HI_ADDR = 7'h0E,
  parameter logic [ADDR_W-1:0] IN_LO_ADDR  = 7'h0B,
  parameter logic [ADDR_W-1:0] IN_HI_ADDR  = 7'h0C,
  parameter logic [3:0]        WRITE_MODE  = 4'd3,
  parameter logic [3:0]        READ_MODE   = 4'd1,
  localparam int PORT_W = $clog2(NUM_PORTS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS*CFG_W-1:0] cfgWords,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [PORT_W-1:0]          reqPort,
  input  logic                       reqLevel,
  output logic                       busy,
  output logic                       rspValid,
  output logic                       rspOk,
  output logic [DATA_W-1:0]          rspData,
  output logic                       busReq,
  output logic                       busWe,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          busWdata,
  input  logic                       busAck,
  input  logic [DATA_W-1:0]          busRdata
);

  engStrobe_t strobes;
  logic       isWrite;
  logic       accessOk;

  gpe_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isWrite  (isWrite),
    .accessOk (accessOk),
    .busAck   (busAck),
    .strobes  (strobes),
    .busReq   (busReq),
    .busWe    (busWe),
    .busy     (busy),
    .rspValid (rspValid)
  );

  gpe_datapath #(
    .NUM_PORTS   (NUM_PORTS),
    .CFG_W       (CFG_W),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .MODE_W      (4),
    .OUT_LO_ADDR (OUT_LO_ADDR),
    .OUT_HI_ADDR (OUT_HI_ADDR),
    .IN_LO_ADDR  (IN_LO_ADDR),
    .IN_HI_ADDR  (IN_HI_ADDR),
    .WRITE_MODE  (WRITE_MODE),
    .READ_MODE   (READ_MODE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqPort  (reqPort),
    .reqLevel (reqLevel),
    .cfgWords (cfgWords),
    .busRdata (busRdata),
    .isWrite  (isWrite),
    .accessOk (accessOk),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rspOk    (rspOk),
    .rspData  (rspData)
  );

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));

  assert_addr_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busAddr == OUT_LO_ADDR || busAddr == OUT_HI_ADDR ||
                (!busWe && (busAddr == IN_LO_ADDR || busAddr == IN_HI_ADDR))));

endmodule

// File: tb/gpio_port_engine_tb_top.sv
module gpio_port_engine_tb_top;

  localparam int NP = 20;
  localparam logic [6:0] OUT_LO = 7'h0D, OUT_HI = 7'h0E, IN_LO = 7'h0B, IN_HI = 7'h0C;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic [NP*16-1:0] cfgWords;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqLevel = 1'b0;
  logic [4:0]    reqPort = '0;
  logic          busy, rspValid, rspOk, busReq, busWe;
  logic [15:0]   rspData, busWdata;
  logic [6:0]    busAddr;
  logic          busAck = 1'b0;
  logic [15:0]   busRdata = '0;

  gpio_port_engine dut_i (
    .clk(clk), .rstN(rstN), .cfgWords(cfgWords),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPort(reqPort), .reqLevel(reqLevel),
    .busy(busy), .rspValid(rspValid), .rspOk(rspOk), .rspData(rspData),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata)
  );

  int checks = 0, errors = 0;
  logic [15:0] regs [0:127];
  int lat = 0, waitCnt = 0, rspSeen = 0, lastOk = 0, lastData = 0;
  int txAddr[$], txWe[$], txData[$];
  bit prevPend = 0;
  logic [6:0] prevAddr; logic prevWe; logic [15:0] prevWd;

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] modeOf(input int p);
    case (p)
      0, 3, 5, 16, 19: return 4'h3;
      1, 2, 17, 18:    return 4'h1;
      4:               return 4'hB;
      6:               return 4'h9;
      7:               return 4'h0;
      8:               return 4'h5;
      default:         return 4'h7;
    endcase
  endfunction

  initial begin
    for (int p = 0; p < NP; p++) begin
      if (p == 7) cfgWords[p*16 +: 16] = 16'h0300;
      else        cfgWords[p*16 +: 16] = {modeOf(p), 12'(p*37 + 5)};
    end
    for (int a = 0; a < 128; a++) regs[a] = 16'(a * 3);
    regs[IN_LO]  = 16'hA5C3;
    regs[IN_HI]  = 16'h000A;
    regs[OUT_LO] = 16'h0F0F;
    regs[OUT_HI] = 16'h0001;
  end

  // Bus slave model and per-clock monitors
  always @(negedge clk) begin
    if (prevPend) check(busReq && busAddr == prevAddr && busWe == prevWe && busWdata == prevWd,
                        "R10", "bus held until ack", int'(busAddr), int'(prevAddr));
    if (rspValid) begin
      rspSeen++;
      lastOk = int'(rspOk);
      lastData = int'(rspData);
      check(busy, "R8", "busy with status", int'(busy), 1);
    end
    if (busReq && rstN) begin
      if (waitCnt >= lat) begin
        busAck = 1'b1;
        busRdata = regs[busAddr];
        txAddr.push_back(int'(busAddr));
        txWe.push_back(int'(busWe));
        txData.push_back(int'(busWdata));
        if (busWe) regs[busAddr] = busWdata;
        waitCnt = 0;
        prevPend = 0;
      end else begin
        busAck = 1'b0;
        waitCnt++;
        prevPend = 1;
        prevAddr = busAddr; prevWe = busWe; prevWd = busWdata;
      end
    end else begin
      busAck = 1'b0;
      waitCnt = 0;
      prevPend = 0;
    end
  end

  task automatic doReq(input bit wr, input int port, input bit lvl, input bit inject,
                       input string tag);
    bit ok, hi;
    int b, c0, n, expTx;
    logic [6:0] outA, inA;
    logic [15:0] newv, rd;
    ok   = (port < NP) && (wr ? (modeOf(port) == 4'h3) : (modeOf(port) == 4'h1));
    hi   = port >= 16;
    b    = hi ? port - 16 : port;
    outA = hi ? OUT_HI : OUT_LO;
    inA  = hi ? IN_HI : IN_LO;
    newv = lvl ? (regs[outA] | (16'd1 << b)) : (regs[outA] & ~(16'd1 << b));
    rd   = regs[inA] >> b;
    expTx = !ok ? 0 : (wr ? 2 : 1);
    c0 = rspSeen;
    txAddr.delete(); txWe.delete(); txData.delete();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqPort = 5'(port); reqLevel = lvl;
    @(negedge clk);
    reqValid = 1'b0;
    #1 check(busy, "R8", "busy after accept", int'(busy), 1);
    if (inject) begin
      reqValid = 1'b1; reqWrite = 1'b0; reqPort = 5'd1;
      @(negedge clk); @(negedge clk);
      reqValid = 1'b0;
    end
    n = 0;
    while (rspSeen == c0 && n < 300) begin
      @(negedge clk); #1; n++;
    end
    check(rspSeen == c0 + 1, tag, "response arrived", rspSeen - c0, 1);
    check(lastOk == int'(ok), tag, "status", lastOk, int'(ok));
    check(lastData == ((ok && !wr) ? int'(rd) : 0), "R9", "response data", lastData,
          (ok && !wr) ? int'(rd) : 0);
    @(negedge clk); #1;
    check(!busy, "R8", "busy released", int'(busy), 0);
    repeat (4) @(negedge clk);
    #1 check(rspSeen == c0 + 1, "R9", "exactly one response", rspSeen - c0, 1);
    check(txAddr.size() == expTx, tag, "bus transfer count", txAddr.size(), expTx);
    if (txAddr.size() == expTx && ok && wr) begin
      check(txAddr[0] == int'(outA) && txWe[0] == 0, "R5", "fetch output word", txAddr[0], int'(outA));
      check(txAddr[1] == int'(outA) && txWe[1] == 1, "R6", "store output word", txAddr[1], int'(outA));
      check(txData[1] == int'(newv), "R6", "modified word", txData[1], int'(newv));
    end
    if (txAddr.size() == expTx && ok && !wr)
      check(txAddr[0] == int'(inA) && txWe[0] == 0, "R5", "fetch input word", txAddr[0], int'(inA));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!busy && !busReq && !rspValid, "R11", "reset state",
             int'({busy, busReq, rspValid}), 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!busy && !busReq && !rspValid, "R11", "idle after reset",
          int'({busy, busReq, rspValid}), 0);

    lat = 0;
    doReq(1, 5, 1, 0, "R6");   // set bit 5 of low output word
    doReq(1, 3, 0, 0, "R6");   // clear bit 3
    doReq(0, 1, 0, 0, "R7");
    doReq(0, 2, 0, 0, "R7");

    lat = 2;
    doReq(1, 16, 0, 0, "R5");  // clear bit 0 of high output word
    doReq(1, 19, 1, 0, "R5");  // set bit 3 of high output word
    doReq(0, 17, 0, 0, "R7");
    doReq(0, 18, 0, 0, "R7");

    doReq(1, 1, 1, 0, "R2");   // mode 1 pin, drive refused
    doReq(0, 0, 0, 0, "R3");   // mode 3 pin, sample refused
    doReq(1, 4, 1, 0, "R1");   // mode 0xB
    doReq(0, 6, 0, 0, "R1");   // mode 0x9
    doReq(1, 7, 1, 0, "R1");   // 3 sitting in bits 11:8
    doReq(0, 8, 0, 0, "R3");
    doReq(1, 20, 1, 0, "R4");
    doReq(0, 31, 0, 0, "R4");

    lat = 5;
    doReq(1, 5, 0, 1, "R8");   // extra request raised while busy
    doReq(0, 1, 0, 1, "R8");
    doReq(1, 0, 1, 0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule